// File: doc/BRIEF.md
# Receive packet CPU read engine

This block lets a host processor pull received packets out of an on-chip word queue one 32-bit word at a time through a small register window. Packets are written into the queue from a fill port, one word per cycle, with a marker on each packet's final word. Every stored packet starts with a 3-word header, then two zero bytes, then the Ethernet bytes from the destination address to the end of the payload, with the frame check sequence already removed.

The host learns that a packet is waiting from a live status bit. It can also use a latched copy of that bit, which drives an interrupt when enabled. To drain a packet it writes a read command with a word count, then reads the data register once per word. The usual sequence has two phases. A short first transfer exposes the header. The byte length in the first header word tells the host how many words remain, and it then issues a second command for them. The engine parses the same header itself, so it always knows where the packet ends. It clamps any command that runs past that point, and the next packet's header becomes the next word.

The smallest legal packet carries a 64-byte frame and occupies 19 words. Its header length field reads 60.

Top module: `rx_cpu_read_engine`

## Requirements
- R1: STATUS (address 0) bit 0 is 1 exactly while at least one packet whose final word has been filled is not yet fully read.
- R2: LATCH (address 1) bit 0 sets on each 0-to-1 change of the ready bit. Writing 1 to LATCH bit 0 clears it. A set in the same cycle as a clear wins.
- R3: irq_o is high exactly when LATCH bit 0 and IRQ_EN (address 2) bit 0 are both 1.
- R4: A write to CMD (address 3) starts a transfer only when bits [2:0] equal 3'b110 and the length in bits [25:16] is non-zero. Any other write leaves the pending word count unchanged. A CMD read returns the pending count in bits [25:16].
- R5: Each read of DATA (address 4) while the pending count is non-zero returns the next stored word in fill order and lowers the count by one.
- R6: The first word read from a packet is its header. Header bits [31:21] hold the byte length L, and the packet occupies 3 + ceil((L+2)/4) words. L = 60 gives 19 words.
- R7: A transfer length larger than the words left in the current packet is cut to that remainder. The word after a packet's last word is the next packet's header.
- R8: A DATA read with a pending count of zero returns 0 and sets the sticky underrun flag, STATUS bit 1. Writing 1 to STATUS bit 1 clears the flag.
- R9: When a packet's last word is read in the same cycle as another packet's final word is filled, the ready bit stays 1 and LATCH does not set.
- R10: After reset the ready, latched, enable, underrun and irq bits are 0, and the pending count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_valid_i | input | 1 | Fill word strobe |
| fill_data_i | input | 32 | Fill word |
| fill_last_i | input | 1 | Marks the final word of a packet |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (side effects on DATA) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_o | output | 1 | Interrupt request |

## Verification
Two events can fall in the same cycle: the host reads the last word of one packet, and the fill port delivers the final word of the next packet. One adds to the packet count and the other subtracts from it. The bench provokes this by pre-filling all but the last word of a second packet, draining the first packet to its last word, and then driving the final DATA read and the final fill word on the same clock edge. It judges the result at the ports: the ready bit must stay 1, the cleared latched bit must not set again, and the second packet must then drain intact, header first.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int DW          = 32;
  localparam int RA_W        = 3;
  localparam int PKT_W       = 10;
  localparam int HDR_LEN_LSB = 21;
  localparam int HDR_LEN_W   = 11;
  localparam int CMD_LEN_LSB = 16;
  localparam int HDR_WORDS   = 3;

  localparam logic [RA_W-1:0] RA_STATUS = 3'd0;
  localparam logic [RA_W-1:0] RA_LATCH  = 3'd1;
  localparam logic [RA_W-1:0] RA_IRQEN  = 3'd2;
  localparam logic [RA_W-1:0] RA_CMD    = 3'd3;
  localparam logic [RA_W-1:0] RA_DATA   = 3'd4;

  localparam logic [2:0] OP_READ = 3'b110;

  // words = header + ceil((len + 2 fill bytes) / 4)
  function automatic logic [PKT_W-1:0] pkt_words(input logic [DW-1:0] hdr);
    logic [HDR_LEN_W+1:0] b;
    b = {2'b00, hdr[HDR_LEN_LSB +: HDR_LEN_W]} + (HDR_LEN_W+2)'(5);
    return PKT_W'(HDR_WORDS) + PKT_W'(b >> 2);
  endfunction
endpackage

// File: rtl/rxr_word_queue.sv
module rxr_word_queue #(
  parameter int DEPTH = 128,
  parameter int DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          wr_ok_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   cnt_q;
  logic          full, rd_ok;

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign wr_ok_o = wr_en_i & ~full;
  assign rd_ok   = rd_en_i & ~empty_o;
  assign head_o  = mem[rptr_q];

  always_ff @(posedge clk_i) begin
    if (wr_ok_o) mem[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ok_o) wptr_q <= wptr_q + 1'b1;
      if (rd_ok)   rptr_q <= rptr_q + 1'b1;
      case ({wr_ok_o, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rxr_status.sv
module rxr_status #(
  parameter int CNT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pkt_in_i,
  input  logic pkt_out_i,
  input  logic latch_clr_i,
  input  logic ie_we_i,
  input  logic ie_d_i,
  output logic ready_o,
  output logic latched_o,
  output logic ie_o,
  output logic irq_o
);
  logic [CNT_W-1:0] pkt_cnt_q;
  logic             rdy_q;

  assign ready_o = (pkt_cnt_q != '0);
  assign irq_o   = latched_o & ie_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_cnt_q <= '0;
      rdy_q     <= 1'b0;
      latched_o <= 1'b0;
      ie_o      <= 1'b0;
    end else begin
      case ({pkt_in_i, pkt_out_i})
        2'b10:   pkt_cnt_q <= pkt_cnt_q + 1'b1;
        2'b01:   pkt_cnt_q <= pkt_cnt_q - 1'b1;
        default: pkt_cnt_q <= pkt_cnt_q;
      endcase
      rdy_q <= ready_o;
      // set beats clear
      if (ready_o && !rdy_q) latched_o <= 1'b1;
      else if (latch_clr_i)  latched_o <= 1'b0;
      if (ie_we_i) ie_o <= ie_d_i;
    end
  end
endmodule

// File: rtl/rxr_xfer_ctrl.sv
module rxr_xfer_ctrl
  import rxr_pkg::*;
#(
  parameter int PW = PKT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic [2:0]    cmd_op_i,
  input  logic [PW-1:0] cmd_len_i,
  input  logic          ready_i,
  input  logic [DW-1:0] head_i,
  input  logic          rd_req_i,
  input  logic          q_empty_i,
  input  logic          undr_clr_i,
  output logic          pop_o,
  output logic          pkt_done_o,
  output logic [PW-1:0] xfer_left_o,
  output logic [PW-1:0] pkt_left_o,
  output logic          in_pkt_o,
  output logic          underrun_o
);
  logic [PW-1:0] pkt_rem, len_clamped;
  logic          start;

  // outside a packet the queue head is the next header
  assign pkt_rem     = in_pkt_o ? pkt_left_o : PW'(pkt_words(head_i));
  assign len_clamped = (cmd_len_i > pkt_rem) ? pkt_rem : cmd_len_i;
  assign start       = cmd_we_i && (cmd_op_i == OP_READ) && (cmd_len_i != '0)
                       && (in_pkt_o || ready_i);
  assign pop_o       = rd_req_i && (xfer_left_o != '0) && !q_empty_i;
  assign pkt_done_o  = pop_o && in_pkt_o && (pkt_left_o == PW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_o    <= 1'b0;
      pkt_left_o  <= '0;
      xfer_left_o <= '0;
      underrun_o  <= 1'b0;
    end else begin
      if (start) begin
        in_pkt_o    <= 1'b1;
        pkt_left_o  <= pkt_rem;
        xfer_left_o <= len_clamped;
      end else if (pop_o) begin
        xfer_left_o <= xfer_left_o - 1'b1;
        pkt_left_o  <= pkt_left_o - 1'b1;
        if (pkt_done_o) in_pkt_o <= 1'b0;
      end
      if (rd_req_i && !pop_o) underrun_o <= 1'b1;
      else if (undr_clr_i)    underrun_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_cpu_read_engine.sv
module rx_cpu_read_engine
  import rxr_pkg::*;
#(
  parameter int QDEPTH = 128
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fill_valid_i,
  input  logic [DW-1:0]   fill_data_i,
  input  logic            fill_last_i,
  input  logic            reg_we_i,
  input  logic            reg_re_i,
  input  logic [RA_W-1:0] reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            irq_o
);
  localparam int CNT_W = $clog2(QDEPTH) + 1;

  logic [DW-1:0]    head;
  logic             q_empty, q_wr_ok;
  logic             ready, latched, ie;
  logic             pop, pkt_done, in_pkt, underrun;
  logic [PKT_W-1:0] xfer_left, pkt_left;
  logic             cmd_we, rd_req, latch_clr, ie_we, undr_clr, pkt_in;

  assign cmd_we    = reg_we_i && (reg_addr_i == RA_CMD);
  assign latch_clr = reg_we_i && (reg_addr_i == RA_LATCH)  && reg_wdata_i[0];
  assign ie_we     = reg_we_i && (reg_addr_i == RA_IRQEN);
  assign undr_clr  = reg_we_i && (reg_addr_i == RA_STATUS) && reg_wdata_i[1];
  assign rd_req    = reg_re_i && !reg_we_i && (reg_addr_i == RA_DATA);
  assign pkt_in    = q_wr_ok && fill_last_i;

  rxr_word_queue #(.DEPTH(QDEPTH), .DW(DW)) u_queue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (fill_valid_i),
    .wr_data_i (fill_data_i),
    .rd_en_i   (pop),
    .head_o    (head),
    .empty_o   (q_empty),
    .wr_ok_o   (q_wr_ok)
  );

  rxr_status #(.CNT_W(CNT_W)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pkt_in_i    (pkt_in),
    .pkt_out_i   (pkt_done),
    .latch_clr_i (latch_clr),
    .ie_we_i     (ie_we),
    .ie_d_i      (reg_wdata_i[0]),
    .ready_o     (ready),
    .latched_o   (latched),
    .ie_o        (ie),
    .irq_o       (irq_o)
  );

  rxr_xfer_ctrl #(.PW(PKT_W)) u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_we_i    (cmd_we),
    .cmd_op_i    (reg_wdata_i[2:0]),
    .cmd_len_i   (reg_wdata_i[CMD_LEN_LSB +: PKT_W]),
    .ready_i     (ready),
    .head_i      (head),
    .rd_req_i    (rd_req),
    .q_empty_i   (q_empty),
    .undr_clr_i  (undr_clr),
    .pop_o       (pop),
    .pkt_done_o  (pkt_done),
    .xfer_left_o (xfer_left),
    .pkt_left_o  (pkt_left),
    .in_pkt_o    (in_pkt),
    .underrun_o  (underrun)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_STATUS: reg_rdata_o = {30'd0, underrun, ready};
      RA_LATCH:  reg_rdata_o = {31'd0, latched};
      RA_IRQEN:  reg_rdata_o = {31'd0, ie};
      RA_CMD:    reg_rdata_o = DW'(xfer_left) << CMD_LEN_LSB;
      RA_DATA:   reg_rdata_o = ((xfer_left != '0) && !q_empty) ? head : '0;
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker
  import rxr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ready,
  input logic             latched,
  input logic             ie,
  input logic             irq,
  input logic             cmd_we,
  input logic [2:0]       cmd_op,
  input logic [PKT_W-1:0] xfer_left,
  input logic [PKT_W-1:0] pkt_left,
  input logic             in_pkt,
  input logic             pop,
  input logic             rd_req,
  input logic             underrun,
  input logic             pkt_in,
  input logic             pkt_done
);
  assert_ready_held_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pkt |-> ready);

  assert_latch_on_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready) |=> latched);

  assert_irq_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq) |-> (ie && latched));

  assert_cmd_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && cmd_op != OP_READ) |=> $stable(xfer_left));

  assert_pop_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> (xfer_left == PKT_W'($past(xfer_left) - 1'b1)));

  assert_clamp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pkt |-> (xfer_left <= pkt_left));

  assert_underrun_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !pop) |=> underrun);

  assert_overlap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_in && pkt_done) |=> (ready == $past(ready)));
endmodule

bind rx_cpu_read_engine rxr_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready     (ready),
  .latched   (latched),
  .ie        (ie),
  .irq       (irq_o),
  .cmd_we    (cmd_we),
  .cmd_op    (reg_wdata_i[2:0]),
  .xfer_left (xfer_left),
  .pkt_left  (pkt_left),
  .in_pkt    (in_pkt),
  .pop       (pop),
  .rd_req    (rd_req),
  .underrun  (underrun),
  .pkt_in    (pkt_in),
  .pkt_done  (pkt_done)
);

// File: tb/tb_rx_cpu_read_engine.sv
module tb_rx_cpu_read_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fv = 1'b0, fl = 1'b0;
  logic [31:0] fd = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int unsigned exp_q[$];

  always #4 clk = ~clk;

  rx_cpu_read_engine dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fill_valid_i(fv), .fill_data_i(fd), .fill_last_i(fl),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int words_of(input int len);
    return 3 + (len + 2 + 3) / 4;
  endfunction

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 re = 1'b0;
  endtask

  task automatic cmd(input int len, input logic [2:0] op);
    reg_wr(3'd3, (32'(len) << 16) | 32'(op));
  endtask

  task automatic pending_is(input string req, input int n);
    logic [31:0] d;
    reg_rd(3'd3, d);
    check(req, 32'(d[25:16]), 32'(n));
  endtask

  // push a packet; store expectations; optionally keep the last word back
  task automatic push_pkt(input int len, input int base, input bit hold_last, output logic [31:0] last_w);
    int n;
    logic [31:0] w;
    n = words_of(len);
    for (int i = 0; i < n; i++) begin
      w = (i == 0) ? {len[10:0], base[20:0]} : 32'(base + i);
      exp_q.push_back(w);
      if (i == n - 1) last_w = w;
      if (!(hold_last && i == n - 1)) begin
        @(negedge clk); fv = 1'b1; fd = w; fl = (i == n - 1);
        @(posedge clk); #1 fv = 1'b0; fl = 1'b0;
      end
    end
  endtask

  task automatic read_n(input string req, input int n);
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin
      reg_rd(3'd4, d);
      check(req, d, exp_q.pop_front());
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(3'd0, d); check("R10 status", d, 32'h0);
    reg_rd(3'd1, d); check("R10 latch", d, 32'h0);
    reg_rd(3'd2, d); check("R10 irq_en", d, 32'h0);
    check("R10 irq", 32'(irq), 32'h0);
    pending_is("R10 pending", 0);
  endtask

  task automatic t_arrival_and_irq();
    logic [31:0] d, lw;
    cmd(5, 3'b110);
    pending_is("R4 no packet", 0);
    push_pkt(60, 32'h1000, 1'b0, lw);
    reg_rd(3'd0, d); check("R1 ready", d, 32'h1);
    reg_rd(3'd1, d); check("R2 latched", d, 32'h1);
    check("R3 irq masked", 32'(irq), 32'h0);
    reg_wr(3'd2, 32'h1);
    check("R3 irq enabled", 32'(irq), 32'h1);
    cmd(4, 3'b101);
    pending_is("R4 bad op", 0);
    cmd(0, 3'b110);
    pending_is("R4 zero len", 0);
  endtask

  task automatic t_two_phase();
    logic [31:0] d;
    cmd(1, 3'b110);
    pending_is("R4 start", 1);
    reg_rd(3'd4, d);
    check("R6 header", d, exp_q.pop_front());
    check("R6 length field", 32'(d[31:21]), 32'd60);
    cmd(words_of(int'(d[31:21])) - 1, 3'b110);
    pending_is("R6 rest of 19", 18);
    read_n("R5 body", 18);
    pending_is("R5 drained", 0);
    reg_rd(3'd0, d); check("R1 ready low", d, 32'h0);
    reg_wr(3'd1, 32'h1);
    reg_rd(3'd1, d); check("R2 w1c", d, 32'h0);
    check("R3 irq low", 32'(irq), 32'h0);
  endtask

  task automatic t_clamp();
    logic [31:0] d, lw;
    push_pkt(65, 32'h2000, 1'b0, lw);
    push_pkt(60, 32'h3000, 1'b0, lw);
    cmd(18, 3'b110);
    pending_is("R7 first 18", 18);
    read_n("R7 pkt a", 18);
    cmd(30, 3'b110);
    pending_is("R7 clamp", 2);
    read_n("R7 pkt a tail", 2);
    reg_rd(3'd0, d); check("R1 second waits", d, 32'h1);
    cmd(1, 3'b110);
    reg_rd(3'd4, d);
    check("R7 next header", d, exp_q.pop_front());
    cmd(40, 3'b110);
    pending_is("R7 clamp b", 18);
    read_n("R5 pkt b", 18);
  endtask

  task automatic t_underrun();
    logic [31:0] d;
    reg_rd(3'd4, d); check("R8 zero data", d, 32'h0);
    reg_rd(3'd0, d); check("R8 sticky", d, 32'h2);
    reg_rd(3'd0, d); check("R8 still set", d, 32'h2);
    reg_wr(3'd0, 32'h2);
    reg_rd(3'd0, d); check("R8 cleared", d, 32'h0);
  endtask

  task automatic t_overlap();
    logic [31:0] d, lw_a, lw_b;
    push_pkt(60, 32'h4000, 1'b0, lw_a);
    push_pkt(60, 32'h5000, 1'b1, lw_b);
    reg_wr(3'd1, 32'h1);
    reg_rd(3'd1, d); check("R2 pre clear", d, 32'h0);
    cmd(1, 3'b110);
    read_n("R9 a header", 1);
    cmd(18, 3'b110);
    read_n("R9 a body", 17);
    // final read of a and final fill of b on one edge
    @(negedge clk);
    re = 1'b1; addr = 3'd4; fv = 1'b1; fd = lw_b; fl = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1 re = 1'b0; fv = 1'b0; fl = 1'b0;
    check("R9 a last", d, exp_q.pop_front());
    reg_rd(3'd0, d); check("R9 ready held", d, 32'h1);
    reg_rd(3'd1, d); check("R9 no latch", d, 32'h0);
    cmd(1, 3'b110);
    read_n("R9 b header", 1);
    cmd(18, 3'b110);
    read_n("R9 b body", 18);
    reg_rd(3'd0, d); check("R1 empty", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_arrival_and_irq();
    t_two_phase();
    t_clamp();
    t_underrun();
    t_overlap();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule